// File: doc/BRIEF.md
# Write Strobe Qualifier

This block sits between the synchronised control lines of an asynchronous byte-wide memory port and the memory core behind it. It watches chip-select, output-enable and write-enable (all active low and already synchronised to the core clock) and turns a valid write access into exactly one single-cycle write request. The request carries the address and data that were captured during the access. It also produces the read request and output-driver enable that the core and the pad logic use during reads.

A write access is the window in which chip-select and write-enable are both sampled low. Either strobe may open or close it. The address is taken when the window opens, which is the later of the two falling edges. The data is taken from the last sample before the window closes, which is the earlier of the two rising edges. A window that is too short, that sees output-enable low, or that happens while the supply is not yet trusted produces no request. After the supply-good flag rises, writes stay locked out for a set number of clock cycles.

The glitch threshold and the power-on lockout are parameters counted in clock cycles. The reset input is asynchronous and active low. Its release is synchronised internally and takes two clock edges.

Top module: `wr_strobe_qual`

## Requirements
- R1: While reset is asserted, and until the first qualified event after it, wr_pulse, rd_en and out_en are 0, and wr_addr, wr_data and rd_addr are all zero.
- R2: A write window ends at the first clock edge that samples ce_n or we_n high. If that window qualifies, wr_pulse is 1 for exactly one cycle, immediately after that edge. Each window gives at most one pulse, and no pulse occurs without a closing window.
- R3: wr_addr holds the addr value sampled at the first edge of the window. This is the later of the two falling strobes. Address changes later in the window are ignored. wr_addr updates when the window closes, whether or not it qualified.
- R4: wr_data holds the din value sampled at the last edge of the window, which is just before the earlier rising strobe. Earlier values of din are overwritten.
- R5: If oe_n is sampled low at any edge of the window, no write pulse is produced.
- R6: A window must span at least GLITCH_CYC sampled edges. A shorter window produces no write pulse.
- R7: The power gate is ready once supply_ok has been sampled high on PWRON_CYC consecutive edges. Any low sample restarts the count. A window produces no pulse if the gate was not ready at any of its edges or at its closing edge.
- R8: out_en equals (ce_n low, oe_n low, we_n high) as sampled at the previous edge.
- R9: rd_en is a one-cycle pulse after an edge where the read condition holds and either did not hold at the previous edge or addr differs from the previous sampled addr. rd_addr then holds that addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above write threshold |
| ce_n | input | 1 | Synchronised chip select, active low |
| oe_n | input | 1 | Synchronised output enable, active low |
| we_n | input | 1 | Synchronised write enable, active low |
| addr | input | ADDR_W | Address bus |
| din | input | DATA_W | Write data bus |
| wr_pulse | output | 1 | One-cycle qualified write request |
| wr_addr | output | ADDR_W | Address captured for the last write window |
| wr_data | output | DATA_W | Data captured for the last write window |
| rd_en | output | 1 | One-cycle read request to the core |
| rd_addr | output | ADDR_W | Address of the last read request |
| out_en | output | 1 | Output driver enable |

## Verification
Several properties are checked on every cycle. The write pulse never lasts two cycles, it only follows an edge that closed a window, and it only follows a window of at least the glitch length. It also needs the power gate to be ready at the closing edge. Separately, out_en follows the sampled read condition, and rd_en only occurs while out_en is high. Other behaviour can only be shown by the bench scenarios that drive whole accesses and compare against the cycle model. This covers which address and data are captured when the two strobes overlap in either order, cancellation by a brief output-enable, the exact glitch boundary, and lockout restarting after a supply dip.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  typedef enum logic {
    WC_IDLE = 1'b0,
    WC_LOW  = 1'b1
  } wc_state_e;

endpackage

// File: rtl/wsq_rst_sync.sv
module wsq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/wsq_pwr_gate.sv
module wsq_pwr_gate #(
  parameter int PWRON_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic wr_ready
);

  localparam int LOCK_W = $clog2(PWRON_CYC + 1);
  localparam logic [LOCK_W-1:0] LOCK_END = LOCK_W'(PWRON_CYC);

  logic [LOCK_W-1:0] cnt_q;
  logic [LOCK_W-1:0] cnt_d;
  logic              cnt_en;

  assign wr_ready = (cnt_q == LOCK_END);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!supply_ok) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (!wr_ready) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + LOCK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/wsq_wr_cycle.sv
module wsq_wr_cycle
  import wsq_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int GLITCH_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_ready,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int LEN_W = $clog2(GLITCH_CYC + 1);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(GLITCH_CYC);

  wc_state_e         state_q, state_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              abort_q, abort_d;
  logic [ADDR_W-1:0] cap_addr_q, cap_addr_d;
  logic [DATA_W-1:0] cap_data_q, cap_data_d;
  logic              pulse_q, pulse_d;
  logic [ADDR_W-1:0] out_addr_q;
  logic [DATA_W-1:0] out_data_q;
  logic              win_low;
  logic              blocked;
  logic              long_enough;
  logic              close_win;

  assign win_low = !ce_n && !we_n;
  assign blocked = !oe_n || !wr_ready;

  generate
    if (GLITCH_CYC <= 1) begin : g_no_filter
      assign long_enough = 1'b1;
    end else begin : g_filter
      assign long_enough = (len_q >= LEN_MIN);
    end
  endgenerate

  always_comb begin
    state_d    = state_q;
    len_d      = len_q;
    abort_d    = abort_q;
    cap_addr_d = cap_addr_q;
    cap_data_d = cap_data_q;
    pulse_d    = 1'b0;
    close_win  = 1'b0;
    unique case (state_q)
      WC_IDLE: begin
        if (win_low) begin
          state_d    = WC_LOW;
          len_d      = LEN_W'(1);
          abort_d    = blocked;
          cap_addr_d = addr;
          cap_data_d = din;
        end
      end
      WC_LOW: begin
        if (win_low) begin
          if (len_q != LEN_MIN) begin
            len_d = len_q + LEN_W'(1);
          end
          abort_d    = abort_q || blocked;
          cap_data_d = din;
        end else begin
          state_d   = WC_IDLE;
          close_win = 1'b1;
          pulse_d   = !abort_q && long_enough && wr_ready;
        end
      end
      default: state_d = WC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WC_IDLE;
      len_q      <= '0;
      abort_q    <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
      pulse_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      len_q      <= len_d;
      abort_q    <= abort_d;
      cap_addr_q <= cap_addr_d;
      cap_data_q <= cap_data_d;
      pulse_q    <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr_q <= '0;
      out_data_q <= '0;
    end else if (close_win) begin
      out_addr_q <= cap_addr_q;
      out_data_q <= cap_data_q;
    end
  end

  assign wr_pulse = pulse_q;
  assign wr_addr  = out_addr_q;
  assign wr_data  = out_data_q;

endmodule

// File: rtl/wsq_rd_ctl.sv
module wsq_rd_ctl #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              out_en
);

  logic              rd_cond;
  logic              rd_start;
  logic              cond_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic              rd_en_q;
  logic [ADDR_W-1:0] rd_addr_q;

  assign rd_cond  = !ce_n && !oe_n && we_n;
  assign rd_start = rd_cond && (!cond_q || (addr != last_addr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q      <= 1'b0;
      last_addr_q <= '0;
      rd_en_q     <= 1'b0;
    end else begin
      cond_q      <= rd_cond;
      last_addr_q <= addr;
      rd_en_q     <= rd_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
    end else if (rd_start) begin
      rd_addr_q <= addr;
    end
  end

  assign rd_en   = rd_en_q;
  assign rd_addr = rd_addr_q;
  assign out_en  = cond_q;

endmodule

// File: rtl/wr_strobe_qual.sv
module wr_strobe_qual #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int GLITCH_CYC = 3,
  parameter int PWRON_CYC  = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              out_en
);

  logic rst_sync_n;
  logic wr_ready;

  wsq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wsq_pwr_gate #(.PWRON_CYC(PWRON_CYC)) u_pwr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .supply_ok (supply_ok),
    .wr_ready  (wr_ready)
  );

  wsq_wr_cycle #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .GLITCH_CYC (GLITCH_CYC)
  ) u_wr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .addr     (addr),
    .din      (din),
    .wr_ready (wr_ready),
    .wr_pulse (wr_pulse),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  wsq_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .addr    (addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .out_en  (out_en)
  );

endmodule

// File: rtl/wsq_checker.sv
module wsq_checker #(
  parameter int GLITCH_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic wr_ready,
  input logic wr_pulse,
  input logic rd_en,
  input logic out_en
);

  localparam int RUN_W = $clog2(GLITCH_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GLITCH_CYC);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!ce_n && !we_n) begin
      if (run_q != RUN_MAX) run_q <= run_q + RUN_W'(1);
    end else begin
      run_q <= '0;
    end
  end

  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  a_r2_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(ce_n || we_n));

  a_r6_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> ($past(run_q) >= RUN_MAX));

  a_r7_ready_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(wr_ready));

  a_r8_out_en_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> $past(!ce_n && !oe_n && we_n));

  a_r9_rd_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> out_en);

endmodule

bind wr_strobe_qual wsq_checker #(.GLITCH_CYC(GLITCH_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .wr_ready (wr_ready),
  .wr_pulse (wr_pulse),
  .rd_en    (rd_en),
  .out_en   (out_en)
);

// File: tb/wr_strobe_qual_test.sv
`timescale 1ns/1ps
module wr_strobe_qual_test;

  localparam int AW = 15;
  localparam int DW = 8;
  localparam int GL = 3;
  localparam int PW = 500;

  logic clk = 1'b0;
  logic rst_n, supply_ok, ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic wr_pulse, rd_en, out_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  int npulse = 0;
  int nrd = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wr_strobe_qual #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_CYC(GL), .PWRON_CYC(PW)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .out_en(out_en)
  );

  // behavioural reference model
  bit m_rs1 = 0, m_rs2 = 0;
  int pcnt = 0;
  bit in_c = 0, ab = 0;
  int len = 0;
  int aq = 0, dq = 0;
  bit e_pulse = 0, e_rd = 0, e_oe = 0, prev_rdc = 0;
  int e_wa = 0, e_wd = 0, e_ra = 0, prev_addr = 0;

  always @(posedge clk) begin
    bit low, rdy, rdc;
    if (!m_rs2) begin
      pcnt = 0; in_c = 0; ab = 0; len = 0; aq = 0; dq = 0;
      e_pulse = 0; e_rd = 0; e_oe = 0; prev_rdc = 0;
      e_wa = 0; e_wd = 0; e_ra = 0; prev_addr = 0;
    end else begin
      rdy = (pcnt == PW);
      low = !ce_n && !we_n;
      e_pulse = 0;
      if (low && !in_c) begin
        in_c = 1; len = 1; aq = int'(addr); dq = int'(din); ab = !oe_n || !rdy;
      end else if (low) begin
        len++; dq = int'(din); ab = ab || !oe_n || !rdy;
      end else if (in_c) begin
        in_c = 0; e_pulse = !ab && (len >= GL) && rdy; e_wa = aq; e_wd = dq;
      end
      if (!supply_ok) pcnt = 0;
      else if (pcnt < PW) pcnt++;
      rdc = !ce_n && !oe_n && we_n;
      e_rd = rdc && (!prev_rdc || int'(addr) != prev_addr);
      if (e_rd) e_ra = int'(addr);
      e_oe = rdc;
      prev_rdc = rdc;
      prev_addr = int'(addr);
    end
    if (!rst_n) begin m_rs1 = 0; m_rs2 = 0; end
    else begin m_rs2 = m_rs1; m_rs1 = 1; end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (wr_pulse) npulse++;
    if (rd_en) nrd++;
    chk(wr_pulse == e_pulse, "R2 wr_pulse", int'(wr_pulse), int'(e_pulse));
    chk(int'(wr_addr) == e_wa, "R3 wr_addr", int'(wr_addr), e_wa);
    chk(int'(wr_data) == e_wd, "R4 wr_data", int'(wr_data), e_wd);
    chk(out_en == e_oe, "R8 out_en", int'(out_en), int'(e_oe));
    chk(rd_en == e_rd, "R9 rd_en", int'(rd_en), int'(e_rd));
    chk(int'(rd_addr) == e_ra, "R9 rd_addr", int'(rd_addr), e_ra);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_we(int a, int d, int n);
    ce_n = 0; oe_n = 1; idle(1);
    addr = AW'(a); din = DW'(d); we_n = 0; idle(n);
    we_n = 1; idle(1);
    ce_n = 1; idle(2);
  endtask

  task automatic wr_ce(int a, int d, int n);
    we_n = 0; oe_n = 1; idle(1);
    addr = AW'(a); din = DW'(d); ce_n = 0; idle(n);
    ce_n = 1; idle(1);
    we_n = 1; idle(2);
  endtask

  task automatic expect_pulses(int base, int exp, string tag);
    chk(npulse - base == exp, tag, npulse - base, exp);
  endtask

  initial begin
    int n0;
    rst_n = 0; supply_ok = 1; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; din = '0;
    idle(3);
    // R1 reset state
    chk(!wr_pulse && !rd_en && !out_en, "R1 controls in reset", int'(wr_pulse | rd_en | out_en), 0);
    chk(wr_addr == 0 && wr_data == 0 && rd_addr == 0, "R1 buses in reset", int'(wr_addr), 0);
    rst_n = 1;
    idle(4);
    // R7 lockout right after power-up
    n0 = npulse; wr_we(16'h0111, 8'h11, 5); expect_pulses(n0, 0, "R7 lockout after power-up");
    idle(PW + 10);
    // R2 WE-controlled write
    n0 = npulse; wr_we(16'h1234, 8'hA5, 4); expect_pulses(n0, 1, "R2 WE-controlled write");
    chk(int'(wr_addr) == 16'h1234, "R3 we write addr", int'(wr_addr), 16'h1234);
    chk(int'(wr_data) == 8'hA5, "R4 we write data", int'(wr_data), 8'hA5);
    // R2 CE-controlled write
    n0 = npulse; wr_ce(16'h0456, 8'h3C, 3); expect_pulses(n0, 1, "R2 CE-controlled write");
    // R3/R4 late address change ignored, last data kept
    n0 = npulse;
    ce_n = 0; idle(1);
    we_n = 0; addr = 15'h0AAA; din = 8'h01; idle(1);
    addr = 15'h0555; din = 8'h02; idle(2);
    din = 8'h77; idle(1);
    we_n = 1; addr = 15'h7FFF; din = 8'hFF; idle(1);
    ce_n = 1; idle(2);
    expect_pulses(n0, 1, "R2 pulse with bus changes");
    chk(int'(wr_addr) == 15'h0AAA, "R3 address from window start", int'(wr_addr), 15'h0AAA);
    chk(int'(wr_data) == 8'h77, "R4 data from last low sample", int'(wr_data), 8'h77);
    // R6 glitch boundary
    n0 = npulse; wr_we(16'h0010, 8'h10, GL - 1); expect_pulses(n0, 0, "R6 short window rejected");
    chk(int'(wr_addr) == 16'h0010, "R3 addr updates on rejected close", int'(wr_addr), 16'h0010);
    n0 = npulse; wr_ce(16'h0020, 8'h20, 1); expect_pulses(n0, 0, "R6 one-cycle ce glitch");
    n0 = npulse; wr_we(16'h0030, 8'h30, GL); expect_pulses(n0, 1, "R6 minimum window accepted");
    // R5 output enable low during window
    n0 = npulse;
    ce_n = 0; oe_n = 1; idle(1);
    we_n = 0; addr = 15'h0040; din = 8'h40; idle(2);
    oe_n = 0; idle(1);
    oe_n = 1; idle(2);
    we_n = 1; idle(1); ce_n = 1; idle(2);
    expect_pulses(n0, 0, "R5 oe low cancels write");
    // R7 supply dip during window, then relock
    n0 = npulse;
    ce_n = 0; idle(1);
    we_n = 0; addr = 15'h0050; din = 8'h50; idle(2);
    supply_ok = 0; idle(1); supply_ok = 1; idle(2);
    we_n = 1; idle(1); ce_n = 1; idle(2);
    expect_pulses(n0, 0, "R7 supply dip cancels write");
    n0 = npulse; wr_we(16'h0060, 8'h60, 4); expect_pulses(n0, 0, "R7 relock after dip");
    idle(PW);
    n0 = npulse; wr_we(16'h0070, 8'h70, 4); expect_pulses(n0, 1, "R7 write after lockout ends");
    // R8/R9 read requests
    n0 = nrd;
    ce_n = 0; oe_n = 0; we_n = 1; addr = 15'h0100; idle(3);
    chk(out_en == 1'b1, "R8 out_en during read", int'(out_en), 1);
    addr = 15'h0101; idle(3);
    chk(nrd - n0 == 2, "R9 read request count", nrd - n0, 2);
    chk(int'(rd_addr) == 15'h0101, "R9 read address", int'(rd_addr), 15'h0101);
    oe_n = 1; idle(2);
    chk(out_en == 1'b0, "R8 out_en off with oe high", int'(out_en), 0);
    ce_n = 1; idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule